// File: doc/BRIEF.md
# Half-Duplex Collision Backoff Controller

This block decides, for a half-duplex Ethernet transmitter, when a frame may be sent again after a collision. It counts the collisions suffered by the current frame. After each collision that falls inside the collision window, it picks a random number of slot times. The range of that pick is a power of two whose exponent follows the collision count up to a cap. It then counts that many slot strobes and pulses `retry_now`. When the frame has collided more often than the programmed retransmission maximum allows, the frame is dropped with a one-cycle `abort_frame` pulse.

Two variants change the wait. An alternate cap can replace the standard exponent limit of ten. A back-pressure option retries at once, with no wait, while back pressure is being applied. A collision that arrives after the collision window has closed is reported as late and is not retried. The surrounding MAC drives `frame_start` when a frame first goes on the wire, `frame_end` when it completes without collision, and `collision` while an attempt is in progress. It supplies `slot_tick` once per slot time and resends whenever `retry_now` pulses.

Top module: `hdx_backoff_ctrl`

## Requirements
- R1: After reset, `retry_now`, `abort_frame` and `late_collision` are low and `coll_count` is zero.
- R2: A collision during an attempt, counted in cycles since that attempt began and inside the window, raises `coll_count` by one in the next cycle. `frame_start` clears the count and begins an attempt. `frame_end` during an attempt, with no collision in the same cycle, clears the count and ends the frame.
- R3: A 10-bit free-running LFSR, reset to 1, shifts every cycle with the new bit 0 = bit 9 XOR bit 6. At an accepted collision, its value before the shift, masked to its low e bits, gives the number of slot strobes to wait. The controller then pulses `retry_now` in the cycle after the strobe that completes the wait, or in the cycle after the collision if the masked value is zero.
- R4: With `cfg_alt_en` low, e = min(n, 10), where n is the new collision count.
- R5: With `cfg_alt_en` high, e = min(n, `cfg_alt_cap`, 10).
- R6: With both `cfg_bp_nobackoff` and `bp_active` high, an accepted collision gives `retry_now` in the next cycle. No draw and no wait take place. If either signal is low, the normal backoff applies.
- R7: If a collision inside the window would make the count exceed `cfg_retry_max`, `abort_frame` pulses for one cycle, `coll_count` returns to zero and the frame ends with no retry.
- R8: A collision that arrives when the attempt has already lasted `cfg_coll_window` cycles or more pulses `late_collision` for one cycle. It causes no retry and no abort, leaves `coll_count` unchanged and ends the frame.
- R9: `collision` and `frame_end` have no effect while no attempt is in progress. This covers both idle and the backoff wait. At most one of the three pulse outputs is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_start | input | 1 | First attempt of a new frame begins |
| frame_end | input | 1 | Current attempt completed without collision |
| collision | input | 1 | Collision seen on the medium |
| slot_tick | input | 1 | One pulse per slot time |
| bp_active | input | 1 | Back pressure is currently being applied |
| cfg_alt_en | input | 1 | Use the programmable exponent cap |
| cfg_alt_cap | input | 4 | Programmable exponent cap |
| cfg_bp_nobackoff | input | 1 | Retry immediately under back pressure |
| cfg_retry_max | input | 4 | Largest collision count that is still retried |
| cfg_coll_window | input | 8 | Collision window length in cycles |
| retry_now | output | 1 | One-cycle pulse: resend the frame |
| abort_frame | output | 1 | One-cycle pulse: frame dropped after too many collisions |
| late_collision | output | 1 | One-cycle pulse: collision after the window |
| coll_count | output | 5 | Collisions of the current frame |

## Verification
The hardest state to reach is a collision count above ten, with the standard cap still in force, followed by the abort on the sixteenth collision. Each of those attempts waits up to 1023 slot times, and the draw comes from the LFSR, which the bench cannot steer. The stimulus strobes `slot_tick` every cycle during that run, and it raises `collision` a few cycles after each `retry_now`, so that the collision falls inside the window. A behavioural model in the bench tracks the LFSR and the wait cycle by cycle. Each measured wait is compared against the model's draw and against the bound 2^e − 1.

// File: rtl/hdx_backoff_pkg.sv
package hdx_backoff_pkg;

  typedef enum logic [1:0] {
    BO_IDLE = 2'd0,
    BO_TX   = 2'd1,
    BO_WAIT = 2'd2
  } bo_state_e;

  // Exponent of the backoff range: the collision count, limited by the
  // active cap and by the width of the random source.
  function automatic int hdx_backoff_exp(int n, bit alt_en, int alt_cap,
                                         int std_cap, int src_bits);
    int cap;
    int e;
    cap = alt_en ? alt_cap : std_cap;
    e = n;
    if (e > cap) e = cap;
    if (e > src_bits) e = src_bits;
    return e;
  endfunction

  // True when a collision count no longer earns a retry.
  function automatic bit hdx_over_limit(int next_n, int limit);
    return next_n > limit;
  endfunction

endpackage

// File: rtl/hdx_lfsr.sv
module hdx_lfsr #(
  parameter int W     = 10,
  parameter int TAP_A = 9,
  parameter int TAP_B = 6,
  parameter int SEED  = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  output logic [W-1:0] value
);
  logic [W-1:0] sr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr_q <= W'(SEED);
    else        sr_q <= {sr_q[W-2:0], sr_q[TAP_A] ^ sr_q[TAP_B]};
  end

  assign value = sr_q;
endmodule

// File: rtl/hdx_window_timer.sv
module hdx_window_timer #(
  parameter int WIN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             run,
  input  logic [WIN_W-1:0] limit,
  output logic             is_late
);
  localparam logic [WIN_W-1:0] SAT = {WIN_W{1'b1}};
  logic [WIN_W-1:0] age_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     age_q <= '0;
    else if (restart)               age_q <= '0;
    else if (run && age_q != SAT)   age_q <= age_q + 1'b1;
  end

  assign is_late = (age_q >= limit);
endmodule

// File: rtl/hdx_slot_counter.sv
module hdx_slot_counter #(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         flush,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         gate,
  input  logic         tick,
  output logic         expire
);
  logic [W-1:0] left_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                            left_q <= '0;
    else if (flush)                        left_q <= '0;
    else if (load)                         left_q <= load_val;
    else if (gate && tick && left_q != '0) left_q <= left_q - 1'b1;
  end

  assign expire = gate && tick && (left_q == W'(1));
endmodule

// File: rtl/hdx_backoff_ctrl.sv
module hdx_backoff_ctrl
  import hdx_backoff_pkg::*;
#(
  parameter int RMAX_W  = 4,
  parameter int CAP_W   = 4,
  parameter int WIN_W   = 8,
  parameter int LFSR_W  = 10,
  parameter int STD_CAP = 10,
  parameter int CNT_W   = RMAX_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_start,
  input  logic              frame_end,
  input  logic              collision,
  input  logic              slot_tick,
  input  logic              bp_active,
  input  logic              cfg_alt_en,
  input  logic [CAP_W-1:0]  cfg_alt_cap,
  input  logic              cfg_bp_nobackoff,
  input  logic [RMAX_W-1:0] cfg_retry_max,
  input  logic [WIN_W-1:0]  cfg_coll_window,
  output logic              retry_now,
  output logic              abort_frame,
  output logic              late_collision,
  output logic [CNT_W-1:0]  coll_count
);
  bo_state_e state_q, state_nx;
  logic [CNT_W-1:0]  cnt_q, cnt_nx, next_cnt;
  logic              retry_q, abort_q, late_q;
  logic [LFSR_W-1:0] rnd, draw_mask, draw;
  logic              win_late;
  logic              expire;
  int                exp_used;

  // Named internal events, also observed by the checker.
  logic in_idle, in_tx, in_wait;
  logic ev_coll, ev_late, ev_norm, ev_abort, ev_retry_req;
  logic ev_bp, ev_zero, ev_wait, ev_expire, ev_end, enter_tx;

  hdx_lfsr #(.W(LFSR_W), .TAP_A(LFSR_W - 1), .TAP_B(LFSR_W - 4), .SEED(1)) u_rng (
    .clk   (clk),
    .rst_n (rst_n),
    .value (rnd)
  );

  assign in_idle  = (state_q == BO_IDLE);
  assign in_tx    = (state_q == BO_TX);
  assign in_wait  = (state_q == BO_WAIT);
  assign next_cnt = cnt_q + CNT_W'(1);

  always_comb begin
    exp_used = hdx_backoff_exp(int'(next_cnt), cfg_alt_en, int'(cfg_alt_cap),
                               STD_CAP, LFSR_W);
  end

  for (genvar i = 0; i < LFSR_W; i++) begin : g_mask
    assign draw_mask[i] = (i < exp_used);
  end
  assign draw = rnd & draw_mask;

  assign ev_coll      = in_tx && collision && !frame_start;
  assign ev_late      = ev_coll && win_late;
  assign ev_norm      = ev_coll && !win_late;
  assign ev_abort     = ev_norm && hdx_over_limit(int'(next_cnt), int'(cfg_retry_max));
  assign ev_retry_req = ev_norm && !ev_abort;
  assign ev_bp        = ev_retry_req && bp_active && cfg_bp_nobackoff;
  assign ev_zero      = ev_retry_req && !ev_bp && (draw == '0);
  assign ev_wait      = ev_retry_req && !ev_bp && (draw != '0);
  assign ev_expire    = expire && !frame_start;
  assign ev_end       = in_tx && frame_end && !collision && !frame_start;
  assign enter_tx     = frame_start || ev_bp || ev_zero || ev_expire;

  hdx_window_timer #(.WIN_W(WIN_W)) u_win (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (enter_tx),
    .run     (in_tx),
    .limit   (cfg_coll_window),
    .is_late (win_late)
  );

  hdx_slot_counter #(.W(LFSR_W)) u_slots (
    .clk      (clk),
    .rst_n    (rst_n),
    .flush    (frame_start),
    .load     (ev_wait),
    .load_val (draw),
    .gate     (in_wait),
    .tick     (slot_tick),
    .expire   (expire)
  );

  always_comb begin
    state_nx = state_q;
    cnt_nx   = cnt_q;
    if (frame_start) begin
      state_nx = BO_TX;
      cnt_nx   = '0;
    end else if (ev_late) begin
      state_nx = BO_IDLE;
    end else if (ev_abort) begin
      state_nx = BO_IDLE;
      cnt_nx   = '0;
    end else if (ev_retry_req) begin
      cnt_nx   = next_cnt;
      state_nx = ev_wait ? BO_WAIT : BO_TX;
    end else if (ev_expire) begin
      state_nx = BO_TX;
    end else if (ev_end) begin
      state_nx = BO_IDLE;
      cnt_nx   = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= BO_IDLE;
      cnt_q   <= '0;
      retry_q <= 1'b0;
      abort_q <= 1'b0;
      late_q  <= 1'b0;
    end else begin
      state_q <= state_nx;
      cnt_q   <= cnt_nx;
      retry_q <= !frame_start && (ev_bp || ev_zero || ev_expire);
      abort_q <= !frame_start && ev_abort;
      late_q  <= !frame_start && ev_late;
    end
  end

  assign retry_now      = retry_q;
  assign abort_frame    = abort_q;
  assign late_collision = late_q;
  assign coll_count     = cnt_q;
endmodule

// File: rtl/hdx_backoff_ctrl_sva.sv
module hdx_backoff_ctrl_sva #(
  parameter int CNT_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             frame_start,
  input logic             slot_tick,
  input logic             retry_now,
  input logic             abort_frame,
  input logic             late_collision,
  input logic [CNT_W-1:0] coll_count,
  input logic             ev_bp,
  input logic             ev_late,
  input logic             ev_retry_req,
  input logic             in_idle,
  input logic             in_wait
);
  AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> coll_count == '0); // R2

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    ev_retry_req |=> coll_count == $past(coll_count) + CNT_W'(1)); // R2

  AST_WAIT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    in_wait && !slot_tick && !frame_start |=> !retry_now); // R3

  AST_BP_IMMEDIATE: assert property (@(posedge clk) disable iff (!rst_n)
    ev_bp |=> retry_now); // R6

  AST_ABORT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    abort_frame |-> coll_count == '0); // R7

  AST_ABORT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    abort_frame |=> !abort_frame); // R7

  AST_LATE_NO_RETRY: assert property (@(posedge clk) disable iff (!rst_n)
    ev_late |=> late_collision && !retry_now && $stable(coll_count)); // R8

  AST_IDLE_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
    in_idle && !frame_start |=> !retry_now && !abort_frame && !late_collision); // R9

  AST_ONE_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({retry_now, abort_frame, late_collision})); // R9
endmodule

bind hdx_backoff_ctrl hdx_backoff_ctrl_sva #(.CNT_W(CNT_W)) u_sva (
  .clk            (clk),
  .rst_n          (rst_n),
  .frame_start    (frame_start),
  .slot_tick      (slot_tick),
  .retry_now      (retry_now),
  .abort_frame    (abort_frame),
  .late_collision (late_collision),
  .coll_count     (coll_count),
  .ev_bp          (ev_bp),
  .ev_late        (ev_late),
  .ev_retry_req   (ev_retry_req),
  .in_idle        (in_idle),
  .in_wait        (in_wait)
);

// File: tb/hdx_backoff_ctrl_test.sv
module hdx_backoff_ctrl_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic frame_start = 0, frame_end = 0, collision = 0, slot_tick = 0, bp_active = 0;
  logic cfg_alt_en = 0, cfg_bp_nobackoff = 0;
  logic [3:0] cfg_alt_cap = 4'd10;
  logic [3:0] cfg_retry_max = 4'd15;
  logic [7:0] cfg_coll_window = 8'd64;
  logic retry_now, abort_frame, late_collision;
  logic [4:0] coll_count;

  int checks = 0, bad = 0, cyc = 0;
  int tick_period = 1, tick_div = 0;
  bit waiting = 0;
  int ticks_seen = 0;

  // reference model state
  int m_st = 0, m_cnt = 0, m_win = 0, m_rem = 0, m_lfsr = 1, m_draw = 0;
  int m_retry = 0, m_abort = 0, m_late = 0;

  always #2.5 clk = ~clk;

  hdx_backoff_ctrl uut (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .frame_end(frame_end),
    .collision(collision), .slot_tick(slot_tick), .bp_active(bp_active),
    .cfg_alt_en(cfg_alt_en), .cfg_alt_cap(cfg_alt_cap),
    .cfg_bp_nobackoff(cfg_bp_nobackoff), .cfg_retry_max(cfg_retry_max),
    .cfg_coll_window(cfg_coll_window), .retry_now(retry_now),
    .abort_frame(abort_frame), .late_collision(late_collision),
    .coll_count(coll_count)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  // slot strobe source
  always @(negedge clk) begin
    if (tick_period == 0) slot_tick <= 1'b0;
    else begin
      slot_tick <= (tick_div == 0);
      tick_div  <= (tick_div + 1 >= tick_period) ? 0 : tick_div + 1;
    end
  end

  always @(posedge clk) if (waiting && slot_tick) ticks_seen++;

  // behavioural reference
  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      m_st = 0; m_cnt = 0; m_win = 0; m_rem = 0; m_lfsr = 1;
      m_retry = 0; m_abort = 0; m_late = 0;
    end else begin
      int e, cap;
      m_retry = 0; m_abort = 0; m_late = 0;
      if (frame_start) begin
        m_st = 1; m_cnt = 0; m_win = 0; m_rem = 0;
      end else if (m_st == 1) begin
        if (collision) begin
          if (m_win >= int'(cfg_coll_window)) begin
            m_late = 1; m_st = 0;
          end else if (m_cnt + 1 > int'(cfg_retry_max)) begin
            m_abort = 1; m_cnt = 0; m_st = 0;
          end else begin
            m_cnt++;
            if (bp_active && cfg_bp_nobackoff) begin
              m_retry = 1; m_win = 0; m_draw = 0;
            end else begin
              cap = cfg_alt_en ? int'(cfg_alt_cap) : 10;
              e = (m_cnt < cap) ? m_cnt : cap;
              if (e > 10) e = 10;
              m_draw = m_lfsr % (1 << e);
              if (m_draw == 0) begin m_retry = 1; m_win = 0; end
              else begin m_st = 2; m_rem = m_draw; end
            end
          end
        end else if (frame_end) begin
          m_cnt = 0; m_st = 0;
        end else if (m_win < 255) m_win++;
      end else if (m_st == 2 && slot_tick) begin
        if (m_rem == 1) begin m_rem = 0; m_st = 1; m_win = 0; m_retry = 1; end
        else m_rem--;
      end
      m_lfsr = ((m_lfsr << 1) & 1023) | (((m_lfsr >> 9) ^ (m_lfsr >> 6)) & 1);
    end
  end

  // cycle compare
  always @(negedge clk) if (rst_n) begin
    chk(int'(retry_now) == m_retry, "R3 retry_now", int'(retry_now), m_retry);
    chk(int'(abort_frame) == m_abort, "R7 abort_frame", int'(abort_frame), m_abort);
    chk(int'(late_collision) == m_late, "R8 late_collision", int'(late_collision), m_late);
    chk(int'(coll_count) == m_cnt, "R2 coll_count", int'(coll_count), m_cnt);
  end

  // watchdog
  always @(posedge clk) if (cyc > 150000) begin
    bad++; checks++;
    $display("FAIL watchdog actual=%0d expected<=150000", cyc);
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  task automatic pulse_start();
    @(negedge clk) frame_start = 1; @(negedge clk) frame_start = 0;
  endtask

  // collide, then wait until the collision is resolved; returns slot strobes used
  task automatic collide(output int ticks);
    int guard;
    @(negedge clk) collision = 1;
    @(negedge clk) collision = 0;
    ticks = 0;
    if (retry_now || abort_frame || late_collision) return;
    ticks_seen = 0; waiting = 1; guard = 0;
    while (!retry_now && !abort_frame && !late_collision && guard < 5000) begin
      @(negedge clk); guard++;
    end
    waiting = 0; ticks = ticks_seen;
  endtask

  function automatic int bound(int n, int cap);
    int e;
    e = (n < cap) ? n : cap;
    if (e > 10) e = 10;
    return (1 << e) - 1;
  endfunction

  initial begin
    int t;
    repeat (3) @(negedge clk);
    chk(!retry_now && !abort_frame && !late_collision, "R1 pulses idle", int'(retry_now), 0);
    chk(coll_count == 0, "R1 count zero", int'(coll_count), 0);
    @(negedge clk) rst_n = 1;
    repeat (2) @(negedge clk);

    // basic backoff, then successful end
    tick_period = 3;
    pulse_start();
    for (int i = 1; i <= 3; i++) begin
      collide(t);
      chk(t == m_draw, "R3 wait equals draw", t, m_draw);
      chk(int'(coll_count) == i, "R2 count step", int'(coll_count), i);
      repeat (2) @(negedge clk);
    end
    @(negedge clk) frame_end = 1; @(negedge clk) frame_end = 0;
    chk(coll_count == 0, "R2 end clears", int'(coll_count), 0);

    // alternate cap of 2
    tick_period = 1; cfg_alt_en = 1; cfg_alt_cap = 4'd2;
    pulse_start();
    for (int i = 1; i <= 6; i++) begin
      collide(t);
      chk(t <= bound(i, 2), "R5 alt cap bound", t, bound(i, 2));
      repeat (2) @(negedge clk);
    end
    pulse_start();
    chk(coll_count == 0, "R2 start clears", int'(coll_count), 0);
    cfg_alt_en = 0; cfg_alt_cap = 4'd10;

    // standard cap, run to abort
    pulse_start();
    for (int i = 1; i <= 16; i++) begin
      collide(t);
      if (i <= 15) begin
        chk(t <= bound(i, 10), "R4 std cap bound", t, bound(i, 10));
        chk(retry_now == 1, "R4 retry after wait", int'(retry_now), 1);
      end else begin
        chk(abort_frame == 1, "R7 abort on 16th", int'(abort_frame), 1);
        chk(coll_count == 0, "R7 count cleared", int'(coll_count), 0);
      end
      repeat (2) @(negedge clk);
    end

    // small retransmission maximum
    cfg_retry_max = 4'd2;
    pulse_start();
    for (int i = 1; i <= 3; i++) begin
      collide(t);
      repeat (1) @(negedge clk);
    end
    chk(coll_count == 0, "R7 small max abort", int'(coll_count), 0);
    cfg_retry_max = 4'd15;

    // back pressure without backoff
    cfg_bp_nobackoff = 1; bp_active = 1;
    pulse_start();
    for (int i = 1; i <= 4; i++) begin
      @(negedge clk) collision = 1; @(negedge clk) collision = 0;
      chk(retry_now == 1, "R6 immediate retry", int'(retry_now), 1);
      @(negedge clk);
    end
    bp_active = 0;
    collide(t);
    chk(t == m_draw, "R6 normal when bp inactive", t, m_draw);
    cfg_bp_nobackoff = 0;
    @(negedge clk) frame_end = 1; @(negedge clk) frame_end = 0;

    // late collision
    pulse_start();
    collide(t);
    repeat (70) @(negedge clk);
    @(negedge clk) collision = 1; @(negedge clk) collision = 0;
    chk(late_collision == 1 && retry_now == 0, "R8 late flagged", int'(late_collision), 1);
    chk(coll_count == 1, "R8 count kept", int'(coll_count), 1);

    // ignored while idle
    repeat (3) begin @(negedge clk) collision = 1; frame_end = 1; end
    @(negedge clk) collision = 0; frame_end = 0;
    chk(coll_count == 1 && !retry_now && !abort_frame, "R9 idle ignores", int'(coll_count), 1);

    // zero window: every collision late
    cfg_coll_window = 8'd0;
    pulse_start();
    @(negedge clk) collision = 1; @(negedge clk) collision = 0;
    chk(late_collision == 1, "R8 zero window", int'(late_collision), 1);
    cfg_coll_window = 8'd64;

    repeat (5) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule